// File: doc/BRIEF.md
# External Interrupt Edge Sensing Unit

This block turns a small group of asynchronous input pins into a single interrupt request line for a processor core. A selection mask picks which pins take part. The selected pins are brought into the clock domain by a synchronizer, combined by a logical OR, and passed to a detector. Software chooses through a configuration write port whether the combined line requests on a rising edge, a falling edge, either edge, or on a falling edge together with a held low level.

In the edge modes the detected event is stored in a pending flag. The flag stays set until the core signals that it has entered the service routine for this line. No software write is needed to clear it. In the low-level mode nothing is stored, and the request simply tracks the synchronized line.

A separate wake output is built from the raw pins without going through the synchronizer. It can therefore bring the processor out of halt while the clock is stopped.

Top module: `extint_edge_unit`

## Requirements
- R1: After reset the request and the wake output are low, no pin is selected (mask all zero) and the sensitivity is rising edge (code 01).
- R2: A cycle with `cfg_we_i` high loads `cfg_sens_i` and `cfg_mask_i` at that clock edge, and the new setting governs the outputs from the following cycle.
- R3: Only pins whose mask bit is 1 affect the request. The selected pins are ORed into one line, and a pin with a 0 mask bit has no effect on `irq_o` or `wake_o`.
- R4: With code 01, a low-to-high change of the combined line makes `irq_o` high after the third rising clock edge that samples the new pin value (two synchronizer stages plus the pending flag).
- R5: With code 10, only a high-to-low change of the combined line sets the request, with the same latency as R4.
- R6: With code 11, both a rise and a fall of the combined line set the request, with the same latency as R4.
- R7: With code 00, `irq_o` is high exactly while the synchronized combined line is low and at least one pin is selected. No flag is stored, and the request follows a pin change after the second rising edge.
- R8: In the edge modes the request stays high until a cycle with `ack_i` high. That clock edge clears it.
- R9: If a new edge event falls in the same cycle as `ack_i`, the request stays high, so the event is not lost.
- R10: With an all-zero mask, `irq_o` and `wake_o` stay low for every pin pattern and every mode.
- R11: `wake_o` is combinational from the raw pins and is high when any of these holds: the request is high; or a pin is selected and the raw combined line is low (code 00); or it is high while the last sampled line was low (code 01); or it is low while the last sampled line was high (code 10); or it differs from the last sampled line (code 11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external pins |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sens_i | input | 2 | Sensitivity code: 00 fall+low, 01 rise, 10 fall, 11 both |
| cfg_mask_i | input | NUM_PINS | Pin selection mask, 1 = pin takes part |
| ack_i | input | 1 | Service-routine entry acknowledge for this line |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Halt wake request, clock-free path |

## Verification
The bench sweeps every mode, every mask and every start pattern of a four-pin group, and for each one flips a single pin. This catches a design that lets unselected pins through, that detects the edge in the wrong direction, or that looks at one pin instead of the OR. Latency is checked one cycle early as well as on time, so an extra or a missing synchronizer stage shows up as a request at the wrong edge. A directed case lands an edge in the same cycle as the acknowledge; a design that gives the clear priority would drop that event. The raw wake path is checked in the same time step as the pin change, so a wake taken after the synchronizer would be reported.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENS_FALL_LOW = 2'b00,
        SENS_RISE     = 2'b01,
        SENS_FALL     = 2'b10,
        SENS_BOTH     = 2'b11
    } sens_e;

    typedef struct packed {
        logic prev;   // last sampled combined line
        logic pend;   // latched edge event
    } det_state_t;

    localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_i,     // synchronized combined line
    input  logic  any_sel_i,
    input  sens_e sens_i,
    input  logic  ack_i,
    output logic  irq_o,
    output logic  edge_o,
    output logic  prev_o
);

    det_state_t st_d, st_q;
    logic rise, fall, evt, lvl_mode;

    always_comb begin
        rise     = line_i & ~st_q.prev;
        fall     = ~line_i & st_q.prev;
        lvl_mode = (sens_i == SENS_FALL_LOW);
        unique case (sens_i)
            SENS_RISE: evt = rise;
            SENS_FALL: evt = fall;
            SENS_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
        evt = evt & any_sel_i;

        st_d.prev = line_i;
        if (lvl_mode || !any_sel_i) st_d.pend = 1'b0;
        else                        st_d.pend = evt | (st_q.pend & ~ack_i);

        irq_o  = any_sel_i & (lvl_mode ? ~line_i : st_q.pend);
        edge_o = evt;
        prev_o = st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/extint_wake.sv
module extint_wake
    import extint_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] raw_i,
    input  logic [WIDTH-1:0] mask_i,
    input  sens_e            sens_i,
    input  logic             prev_i,
    input  logic             irq_i,
    output logic             wake_o
);

    logic raw_line, raw_hit, any_sel;

    always_comb begin
        raw_line = |(raw_i & mask_i);
        any_sel  = |mask_i;
        unique case (sens_i)
            SENS_FALL_LOW: raw_hit = ~raw_line;
            SENS_RISE:     raw_hit = raw_line & ~prev_i;
            SENS_FALL:     raw_hit = ~raw_line & prev_i;
            default:       raw_hit = raw_line ^ prev_i;
        endcase
        wake_o = irq_i | (any_sel & raw_hit);
    end

endmodule

// File: rtl/extint_edge_unit.sv
module extint_edge_unit
    import extint_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 4,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                cfg_we_i,
    input  logic [1:0]          cfg_sens_i,
    input  logic [NUM_PINS-1:0] cfg_mask_i,
    input  logic                ack_i,
    output logic                irq_o,
    output logic                wake_o
);

    typedef struct packed {
        sens_e               sens;
        logic [NUM_PINS-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            cfg_d.sens = sens_e'(cfg_sens_i);
            cfg_d.mask = cfg_mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sens <= SENS_RISE;
            cfg_q.mask <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic [NUM_PINS-1:0] sync_pins;
    logic [NUM_PINS-1:0] mask_cur;
    sens_e               sens_cur;
    logic                line, any_sel, edge_evt, prev_line;

    assign mask_cur = cfg_q.mask;
    assign sens_cur = cfg_q.sens;
    assign line     = |(sync_pins & mask_cur);
    assign any_sel  = |mask_cur;

    extint_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (sync_pins)
    );

    extint_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line),
        .any_sel_i(any_sel),
        .sens_i   (sens_cur),
        .ack_i    (ack_i),
        .irq_o    (irq_o),
        .edge_o   (edge_evt),
        .prev_o   (prev_line)
    );

    extint_wake #(.WIDTH(NUM_PINS)) u_wake (
        .raw_i (pin_i),
        .mask_i(mask_cur),
        .sens_i(sens_cur),
        .prev_i(prev_line),
        .irq_i (irq_o),
        .wake_o(wake_o)
    );

endmodule

// File: rtl/extint_edge_unit_chk.sv
module extint_edge_unit_chk
    import extint_pkg::*;
#(
    parameter int unsigned NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we_i,
    input logic                ack_i,
    input logic                irq_o,
    input logic                edge_evt,
    input sens_e               sens_cur,
    input logic [NUM_PINS-1:0] mask_cur,
    input logic [NUM_PINS-1:0] sync_pins
);

    logic lvl;
    assign lvl = (sens_cur == SENS_FALL_LOW);

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && edge_evt && !cfg_we_i) |=> irq_o); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && ack_i && !edge_evt && !cfg_we_i) |=> !irq_o); // R8

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && irq_o && !ack_i && !cfg_we_i) |=> irq_o); // R8

    AST_LVL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && irq_o) |-> ((sync_pins & mask_cur) == '0)); // R7

endmodule

bind extint_edge_unit extint_edge_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we_i (cfg_we_i),
    .ack_i    (ack_i),
    .irq_o    (irq_o),
    .edge_evt (edge_evt),
    .sens_cur (sens_cur),
    .mask_cur (mask_cur),
    .sync_pins(sync_pins)
);

// File: tb/extint_edge_unit_test.sv
module extint_edge_unit_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic         cfg_we_i = 1'b0;
    logic [1:0]   cfg_sens_i = 2'b00;
    logic [N-1:0] cfg_mask_i = '0;
    logic         ack_i = 1'b0;
    logic         irq_o, wake_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    extint_edge_unit #(.NUM_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we_i(cfg_we_i),
        .cfg_sens_i(cfg_sens_i), .cfg_mask_i(cfg_mask_i), .ack_i(ack_i),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic exp_evt(input int m, input logic oa, input logic ob);
        case (m)
            1: return ob & ~oa;
            2: return oa & ~ob;
            3: return oa ^ ob;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_wake(input int m, input logic any, input logic oa, input logic ob);
        case (m)
            0: return any & (~ob | ~oa);
            default: return any & exp_evt(m, oa, ob);
        endcase
    endfunction

    function automatic string rq(input int m);
        case (m)
            0: return "R7";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_o, 1'b0, "R1", "irq after reset");
        chk(wake_o, 1'b0, "R1", "wake after reset");
        // R1: no pin selected, so a rising pin has no effect
        pin_i = 4'hF;
        #1 chk(wake_o, 1'b0, "R1", "wake with empty mask");
        repeat (3) tick();
        chk(irq_o, 1'b0, "R1", "irq with empty mask");

        // R2: level mode on pin0 low; effect only after the write edge
        pin_i = 4'h0;
        repeat (3) tick();
        cfg_we_i = 1'b1; cfg_sens_i = 2'b00; cfg_mask_i = 4'h1;
        #1 chk(irq_o, 1'b0, "R2", "before config edge");
        tick();
        cfg_we_i = 1'b0;
        chk(irq_o, 1'b1, "R2", "after config edge");

        // Sweep: mode x mask x start pattern x single-pin flip (R3..R8, R10, R11)
        for (int m = 0; m < 4; m++) begin
            for (int mk = 0; mk < 16; mk++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int j = 0; j < N; j++) begin
                        logic [N-1:0] av, bv, mv;
                        logic oa, ob, any, ev;
                        av = a[N-1:0];
                        mv = mk[N-1:0];
                        bv = av ^ (4'h1 << j);
                        oa = |(av & mv);
                        ob = |(bv & mv);
                        any = |mv;
                        ev = any & exp_evt(m, oa, ob);
                        cfg_we_i = 1'b1; cfg_sens_i = m[1:0]; cfg_mask_i = mv;
                        pin_i = av;
                        tick();
                        cfg_we_i = 1'b0;
                        repeat (2) tick();
                        ack_i = 1'b1;
                        tick();
                        ack_i = 1'b0;
                        chk(irq_o, (m == 0) ? (any & ~oa) : 1'b0, "R8", "cleared before flip");
                        pin_i = bv;
                        #1 chk(wake_o, exp_wake(m, any, oa, ob), "R11", "raw wake");
                        repeat (2) tick();
                        if (m == 0) chk(irq_o, any & ~ob, "R7", "level after two edges");
                        else        chk(irq_o, 1'b0, rq(m), "not yet after two edges");
                        tick();
                        if (m == 0) chk(irq_o, any & ~ob, "R7", "level steady");
                        else        chk(irq_o, ev, (mv == 0) ? "R10" : ((mv[j] == 1'b0) ? "R3" : rq(m)), "edge latched");
                        tick();
                        chk(irq_o, (m == 0) ? (any & ~ob) : ev, "R8", "request held");
                    end
                end
            end
        end

        // R9: edge in the same cycle as the acknowledge is kept
        cfg_we_i = 1'b1; cfg_sens_i = 2'b11; cfg_mask_i = 4'h1; pin_i = 4'h0;
        tick();
        cfg_we_i = 1'b0;
        repeat (2) tick();
        ack_i = 1'b1; tick(); ack_i = 1'b0;
        pin_i = 4'h1;
        repeat (3) tick();
        chk(irq_o, 1'b1, "R6", "rise latched in both mode");
        pin_i = 4'h0;
        repeat (2) tick();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        chk(irq_o, 1'b1, "R9", "edge with ack kept");
        tick();
        chk(irq_o, 1'b1, "R9", "still pending after collision");
        ack_i = 1'b1; tick(); ack_i = 1'b0;
        chk(irq_o, 1'b0, "R8", "ack alone clears");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule